// File: doc/BRIEF.md
# Multi-Device Parallel EPROM Read Controller

This block lets a synchronous host read bytes from a bank of byte-wide parallel EPROM devices, each holding 32768 bytes. The host presents a flat byte address with a request and holds both until a one-cycle ready pulse returns the byte. The upper address bits pick a device and the lower 15 bits go out on the shared memory address bus.

On the memory side, each device has its own active-low chip enable and all devices share one active-low output enable. The controller converts the access, output-enable and float times of a chosen speed grade into whole clock cycles, rounding up. It then sequences the enables so that data is sampled only once both delays have elapsed. When the next read goes to a different device, it keeps every enable high for at least the float time first, so that two devices never drive the data bus at once.

Addresses above the configured number of devices never touch the bus and come back with an error flag. Between requests every device sits in standby.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, every bit of `mem_ce_n` and `mem_oe_n` is high and `ready` is low.
- R2: A request selects device `addr[HOST_AW-1:15]` and drives `addr[14:0]` on `mem_addr`. The returned byte is the value that device presents at that location.
- R3: At most one chip enable is low at any time. `mem_oe_n` is low only while a chip enable is low.
- R4: Let the grade times be (access, output-enable, float) = (45,25,25), (60,30,30), (70,35,30) or (80,40,30) ns for `SPEED_GRADE` 0 to 3. Each time converts to cycles as ceil(ns / `CLK_NS`). During an access the chip enable stays low for exactly the access cycle count, and the output enable is low for exactly the output-enable cycle count at the end of that window.
- R5: The data bus is registered at the clock edge that ends the chip-enable window. In the next cycle, `ready` is high for exactly one cycle, with that byte on `rdata` and `err` low.
- R6: `mem_addr` is stable for as long as a chip enable stays low.
- R7: Before a chip enable goes low for a device other than the one used last, all chip enables have been high for at least the float cycle count. Once that time has already passed, the new access starts with no extra wait.
- R8: A request to the same device as the previous access, presented on the cycle `ready` is seen, starts its chip enable two cycles later with no float wait.
- R9: A request whose device index is not below `NUM_DEV` asserts no chip enable. It returns `ready` one cycle after acceptance with `err` high and `rdata` zero, and it does not change which device counts as last used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, held with `addr` until `ready` |
| addr | input | HOST_AW | Flat byte address; upper bits select the device |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Byte read, valid with `ready` |
| err | output | 1 | With `ready`: address beyond the configured devices |
| mem_addr | output | DEV_AW | Shared memory address bus |
| mem_ce_n | output | NUM_DEV | Per-device active-low chip enables |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_data | input | DW | Shared memory data bus |

## Verification
The bench's memory model returns a corrupted byte until chip enable and output enable have each been low long enough. A controller that rounds a delay down, or samples one cycle early, therefore returns wrong data rather than only wrong timing. Back-to-back reads switch between devices, and the bench measures the all-high gap before each switch. A controller that skips the float wait shows a short gap. One that applies the wait to the same device, or after the wait has already expired, shows a slower start than R7 and R8 allow. An out-of-range read between valid ones must produce an error with no enable activity. It must also leave the last-device state alone, so that the next read to that device is not held back.

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
  parameter int NUM_DEV     = 3,
  parameter int HOST_AW     = 17,
  parameter int DEV_AW      = 15,
  parameter int DW          = 8,
  parameter int SPEED_GRADE = 0,
  parameter int CLK_NS      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [HOST_AW-1:0] addr,
  output logic               ready,
  output logic [DW-1:0]      rdata,
  output logic               err,
  output logic [DEV_AW-1:0]  mem_addr,
  output logic [NUM_DEV-1:0] mem_ce_n,
  output logic               mem_oe_n,
  input  logic [DW-1:0]      mem_data
);

  localparam int SEL_W = HOST_AW - DEV_AW;

  function automatic int grade_ns(input int g, input int kind);
    int acc, oe, flt;
    case (g)
      0:       begin acc = 45; oe = 25; flt = 25; end
      1:       begin acc = 60; oe = 30; flt = 30; end
      2:       begin acc = 70; oe = 35; flt = 30; end
      default: begin acc = 80; oe = 40; flt = 30; end
    endcase
    return (kind == 0) ? acc : (kind == 1) ? oe : flt;
  endfunction

  localparam int ACC_CYC  = (grade_ns(SPEED_GRADE, 0) + CLK_NS - 1) / CLK_NS;
  localparam int OE_CYC   = (grade_ns(SPEED_GRADE, 1) + CLK_NS - 1) / CLK_NS;
  localparam int FLT_CYC  = (grade_ns(SPEED_GRADE, 2) + CLK_NS - 1) / CLK_NS;
  localparam int HOLD_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
  localparam int LEAD_CYC = HOLD_CYC - OE_CYC;
  localparam int CW       = $clog2(HOLD_CYC + FLT_CYC + 1) + 1;

  logic              busy;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     flt_cnt;
  logic [SEL_W-1:0]  cur_dev;
  logic [SEL_W-1:0]  last_dev;
  logic              have_last;
  logic [DEV_AW-1:0] addr_q;

  wire [SEL_W-1:0] req_dev    = addr[HOST_AW-1:DEV_AW];
  wire             in_range   = (32'(req_dev) < NUM_DEV);
  wire             must_float = have_last && (req_dev != last_dev) && (flt_cnt != '0);
  wire             fresh      = !busy && req && !ready;
  wire             start      = fresh && in_range && !must_float;
  wire             reject     = fresh && !in_range;
  wire             last_cyc   = busy && (cnt == CW'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      flt_cnt   <= '0;
      cur_dev   <= '0;
      last_dev  <= '0;
      have_last <= 1'b0;
      addr_q    <= '0;
      ready     <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
    end else begin
      ready <= 1'b0;
      err   <= 1'b0;
      if (flt_cnt != '0) flt_cnt <= flt_cnt - 1'b1;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        cur_dev <= req_dev;
        addr_q  <= addr[DEV_AW-1:0];
      end else if (last_cyc) begin
        busy      <= 1'b0;
        ready     <= 1'b1;
        rdata     <= mem_data;
        last_dev  <= cur_dev;
        have_last <= 1'b1;
        flt_cnt   <= CW'(FLT_CYC);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (reject) begin
        ready <= 1'b1;
        err   <= 1'b1;
        rdata <= '0;
      end
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_ce
    assign mem_ce_n[i] = !(busy && (cur_dev == SEL_W'(i)));
  end

  assign mem_oe_n = !(busy && (cnt >= CW'(LEAD_CYC)));
  assign mem_addr = addr_q;

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk #(
  parameter int NUM_DEV     = 3,
  parameter int DEV_AW      = 15,
  parameter int SPEED_GRADE = 0,
  parameter int CLK_NS      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               err,
  input logic [DEV_AW-1:0]  mem_addr,
  input logic [NUM_DEV-1:0] mem_ce_n,
  input logic               mem_oe_n
);

  localparam int ACC_NS = (SPEED_GRADE == 0) ? 45 : (SPEED_GRADE == 1) ? 60 : (SPEED_GRADE == 2) ? 70 : 80;
  localparam int OE_NS  = (SPEED_GRADE == 0) ? 25 : (SPEED_GRADE == 1) ? 30 : (SPEED_GRADE == 2) ? 35 : 40;
  localparam int FLT_NS = (SPEED_GRADE == 0) ? 25 : 30;
  localparam int ACC_C  = (ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_C   = (OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int FLT_C  = (FLT_NS + CLK_NS - 1) / CLK_NS;
  localparam int WIN_C  = (ACC_C > OE_C) ? ACC_C : OE_C;

  wire ce_low = ~&mem_ce_n;
  wire oe_low = !mem_oe_n;

  logic       ce_prev, oe_prev, have_last;
  logic [7:0] ce_run, oe_run, hi_run;
  logic [31:0] dev_idx, last_idx;

  always_comb begin
    dev_idx = 0;
    for (int i = 0; i < NUM_DEV; i++) if (!mem_ce_n[i]) dev_idx = i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev <= 1'b0; oe_prev <= 1'b0; have_last <= 1'b0;
      ce_run <= '0; oe_run <= '0; hi_run <= '0; last_idx <= 0;
    end else begin
      ce_prev <= ce_low;
      oe_prev <= oe_low;
      if (ce_low) begin
        ce_run    <= ce_prev ? ce_run + 1'b1 : 8'd1;
        last_idx  <= dev_idx;
        have_last <= 1'b1;
      end
      if (oe_low) oe_run <= oe_prev ? oe_run + 1'b1 : 8'd1;
      if (!ce_low) hi_run <= !ce_prev ? ((hi_run == 8'hff) ? hi_run : hi_run + 1'b1) : 8'd1;
    end
  end

  assert_one_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ce_n) <= 1);
  assert_oe_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_low |-> ce_low);
  assert_ce_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_prev && !ce_low) |-> (ce_run == 8'(WIN_C)));
  assert_oe_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_prev && !oe_low) |-> (oe_run == 8'(OE_C)));
  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  assert_ready_after_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !err) |-> (ce_prev && !ce_low));
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_low && ce_prev) |-> $stable(mem_addr));
  assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_low && !ce_prev && have_last && (dev_idx != last_idx)) |-> (hi_run >= 8'(FLT_C)));
  assert_err_no_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ready && !ce_low && !ce_prev));

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
  .NUM_DEV(NUM_DEV), .DEV_AW(DEV_AW), .SPEED_GRADE(SPEED_GRADE), .CLK_NS(CLK_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .err(err),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n)
);

// File: tb/eprom_rd_ctrl_bench.sv
module eprom_rd_ctrl_bench;
  localparam int NDEV = 3;
  localparam int CLKP = 8;
  localparam int ACC  = (45 + CLKP - 1) / CLKP;
  localparam int OEC  = (25 + CLKP - 1) / CLKP;
  localparam int FLT  = (25 + CLKP - 1) / CLKP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [16:0] addr = '0;
  logic        ready, err;
  logic [7:0]  rdata, mem_data;
  logic [14:0] mem_addr;
  logic [NDEV-1:0] mem_ce_n;
  logic        mem_oe_n;

  int checks = 0;
  int fails  = 0;
  logic [8:0] expq[$];

  always #(CLKP/2) clk = ~clk;

  eprom_rd_ctrl #(.NUM_DEV(NDEV), .HOST_AW(17), .DEV_AW(15), .DW(8), .SPEED_GRADE(0), .CLK_NS(CLKP))
    u_eprom_rd_ctrl (.clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .ready(ready), .rdata(rdata),
      .err(err), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_data(mem_data));

  function automatic logic [7:0] pat(input int dev, input logic [14:0] a);
    return (a[7:0] + {1'b0, a[14:8]}) ^ (8'(dev) * 8'h35);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // memory model: corrupted byte until both delays met
  int ce_cnt = 0, oe_cnt = 0, sel = 0;
  always_comb begin
    sel = -1;
    for (int i = 0; i < NDEV; i++) if (!mem_ce_n[i]) sel = i;
  end
  always @(posedge clk) begin
    ce_cnt <= (sel >= 0) ? ce_cnt + 1 : 0;
    oe_cnt <= (sel >= 0 && !mem_oe_n) ? oe_cnt + 1 : 0;
  end
  always_comb begin
    if (sel >= 0 && !mem_oe_n)
      mem_data = (ce_cnt + 1 >= ACC && oe_cnt + 1 >= OEC) ? pat(sel, mem_addr) : (pat(sel, mem_addr) ^ 8'hA5);
    else
      mem_data = 8'h00;
  end

  // monitor: scoreboard and bus timing
  int ce_run = 0, oe_run = 0, hi_run = 0, last_dev = -1;
  bit ce_prev = 0, oe_prev = 0;
  always @(negedge clk) if (rst_n) begin
    bit cl, ol;
    cl = (sel >= 0);
    ol = !mem_oe_n;
    if (ready) begin
      logic [8:0] e;
      if (expq.size() == 0) chk(0, "R5 unexpected ready", 1, 0);
      else begin
        e = expq.pop_front();
        chk({err, rdata} == e, "R5/R2/R9 response {err,data}", {err, rdata}, e);
      end
    end
    if (cl && !ce_prev) begin
      chk($countones(~mem_ce_n) == 1, "R3 single chip enable", $countones(~mem_ce_n), 1);
      if (last_dev >= 0 && sel != last_dev)
        chk(hi_run >= FLT, "R7 float gap before new device", hi_run, FLT);
      last_dev = sel;
    end
    if (ol && !cl) chk(0, "R3 oe without ce", 1, 0);
    if (!cl && ce_prev) chk(ce_run == ACC, "R4 ce window", ce_run, ACC);
    if (!ol && oe_prev) chk(oe_run == OEC, "R4 oe window", oe_run, OEC);
    ce_run = cl ? (ce_prev ? ce_run + 1 : 1) : ce_run;
    oe_run = ol ? (oe_prev ? oe_run + 1 : 1) : oe_run;
    hi_run = cl ? 0 : hi_run + 1;
    ce_prev = cl;
    oe_prev = ol;
  end

  task automatic rd(input logic [16:0] a, output int lat);
    int n = 0, d;
    bit saw = 0;
    d = int'(a[16:15]);
    req  = 1'b1;
    addr = a;
    expq.push_back((d < NDEV) ? {1'b0, pat(d, a[14:0])} : 9'h100);
    lat = -1;
    forever begin
      @(negedge clk);
      n++;
      if (!saw && ~&mem_ce_n) begin saw = 1; lat = n; end
      if (ready) break;
    end
    req = 1'b0;
    if (d >= NDEV) chk(!saw, "R9 no chip enable for bad address", saw, 0);
  endtask

  task automatic finish_run;
    chk(expq.size() == 0, "R5 all responses returned", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(&mem_ce_n, "R1 reset ce high", mem_ce_n, 7);
    chk(mem_oe_n, "R1 reset oe high", mem_oe_n, 1);
    chk(!ready, "R1 reset ready low", ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(17'h00010, lat);
    chk(lat == 1, "R7 first access no wait", lat, 1);
    rd(17'h00011, lat);
    chk(lat == 2, "R8 same device back-to-back", lat, 2);
    rd(17'h09234, lat);
    chk(lat >= FLT + 1, "R7 switch waits float", lat, FLT + 1);
    rd(17'h17FFF, lat);
    rd(17'h18000, lat);
    rd(17'h10001, lat);
    chk(lat == 2, "R9/R8 error keeps last device", lat, 2);
    repeat (4) @(negedge clk);
    chk(&mem_ce_n && mem_oe_n, "R1 idle standby", {mem_ce_n, mem_oe_n}, 15);
    rd(17'h07FFF, lat);
    chk(lat == 1, "R7 expired float no wait", lat, 1);
    for (int k = 0; k < 6; k++) rd(17'((k % 3) << 15) | 17'(k * 1111), lat);
    rd(17'h1FFFF, lat);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule